// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the beat addresses for one side of a memory-to-memory copy engine. When it is idle and a start pulse arrives, it takes a start address, a width code, a burst code, an increment enable and a byte count. It also takes the width and burst codes of the opposite side of the copy. It checks the configuration and the alignment of the start address in that same cycle. If both are good, it presents one address per beat on a valid/ready handshake until the byte count is used up.

The beats are grouped into bursts of 1, 4, 8 or 16. A strobe marks the final beat of every burst, and a second strobe marks the final beat of the whole transfer. Wrapping bursts keep each address inside a window of width times beats. The next burst starts at the first address past that window. A bad configuration or a misaligned start raises an error flag instead of starting. The flag stays up until the next accepted start.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_valid_o, block_done_o, last_o, busy_o, addr_err_o and cfg_err_o are all low.
- R2: A start pulse while idle with a good configuration raises addr_valid_o in the next cycle, with addr_o equal to the start address. In incrementing mode each accepted beat advances the address by the beat size. The beat size is 1 byte for width code 1, 2 bytes for code 2 and 4 bytes for code 3.
- R3: Burst codes 5, 6 and 7 are wrapping bursts of 4, 8 and 16 beats. Within a burst, the address bits above the window of beat size times beats stay fixed. Each following burst starts at that window's base plus the window size.
- R4: With incr_en_i low, every beat of the transfer carries the start address.
- R5: Burst codes 0, 1, 2 and 3 give 1, 4, 8 and 16 incrementing beats per burst. block_done_o is high on the final beat of each burst. When fewer beats remain than a burst holds, the final burst is cut short to the remaining beats.
- R6: last_o is high only on the beat that completes the byte count, and block_done_o is also high on that beat. After that beat is accepted, busy_o and addr_valid_o fall in the next cycle.
- R7: While addr_valid_o is high and addr_ready_i is low, addr_o, block_done_o and last_o hold their values.
- R8: A non-wrapping start address must be a multiple of the beat size. A wrapping start address must be a multiple of the beat size times the burst beats. A violation sets addr_err_o and produces no beats.
- R9: cfg_err_o is set, and no beats are produced, in any of these cases: a width code other than 1 to 3 on either side; burst code 4 on either side; a byte count of zero or not a multiple of the beat size; or beat size times burst beats differing between the two sides. A configuration error takes priority, so addr_err_o stays low.
- R10: Error flags keep their value until the next start taken while idle, which reloads both. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | ADDR_W | First beat address |
| width_code_i | input | 3 | Beat size code (1, 2, 3 = 1, 2, 4 bytes) |
| burst_code_i | input | 3 | Burst code (0-3 incrementing, 5-7 wrapping) |
| incr_en_i | input | 1 | Advance the address between beats |
| len_i | input | LEN_W | Transfer length in bytes |
| peer_width_code_i | input | 3 | Width code of the opposite side |
| peer_burst_code_i | input | 3 | Burst code of the opposite side |
| addr_ready_i | input | 1 | Consumer accepts the current beat |
| addr_valid_o | output | 1 | A beat address is presented |
| addr_o | output | ADDR_W | Current beat address |
| block_done_o | output | 1 | Current beat ends a burst |
| last_o | output | 1 | Current beat ends the transfer |
| busy_o | output | 1 | Transfer in progress |
| addr_err_o | output | 1 | Start address misaligned |
| cfg_err_o | output | 1 | Configuration rejected |

## Verification
Beat and burst counters that are out of step would move block_done_o to the wrong beat within one burst length. A wrong remaining-byte count would show as last_o on the wrong beat, or as busy_o staying high, no later than the end of the transfer. Address arithmetic faults show on addr_o at the first accepted beat after the faulty step. Validation faults show as a missing or extra error flag, or as beats produced, in the cycle after the start pulse.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef struct packed {
        logic       ok;
        logic [1:0] lg;     // log2 of beat size in bytes
    } width_dec_t;

    typedef struct packed {
        logic       ok;
        logic       wrap;
        logic [2:0] lg;     // log2 of beats per burst
    } burst_dec_t;

    function automatic width_dec_t dec_width(input logic [2:0] code);
        width_dec_t r;
        case (code)
            3'd1:    r = '{ok: 1'b1, lg: 2'd0};
            3'd2:    r = '{ok: 1'b1, lg: 2'd1};
            3'd3:    r = '{ok: 1'b1, lg: 2'd2};
            default: r = '{ok: 1'b0, lg: 2'd0};
        endcase
        return r;
    endfunction

    function automatic burst_dec_t dec_burst(input logic [2:0] code);
        burst_dec_t r;
        case (code)
            3'd0:    r = '{ok: 1'b1, wrap: 1'b0, lg: 3'd0};
            3'd1:    r = '{ok: 1'b1, wrap: 1'b0, lg: 3'd2};
            3'd2:    r = '{ok: 1'b1, wrap: 1'b0, lg: 3'd3};
            3'd3:    r = '{ok: 1'b1, wrap: 1'b0, lg: 3'd4};
            3'd5:    r = '{ok: 1'b1, wrap: 1'b1, lg: 3'd2};
            3'd6:    r = '{ok: 1'b1, wrap: 1'b1, lg: 3'd3};
            3'd7:    r = '{ok: 1'b1, wrap: 1'b1, lg: 3'd4};
            default: r = '{ok: 1'b0, wrap: 1'b0, lg: 3'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_cfg_check.sv
module burst_cfg_check
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic [2:0]        width_code_i,
    input  logic [2:0]        burst_code_i,
    input  logic [2:0]        peer_width_code_i,
    input  logic [2:0]        peer_burst_code_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              cfg_bad_o,
    output logic              addr_bad_o,
    output logic [1:0]        wlog_o,
    output logic [2:0]        blog_o,
    output logic              wrap_o
);
    width_dec_t w_d, pw_d;
    burst_dec_t b_d, pb_d;
    logic [3:0]        own_sum, peer_sum, align_sh;
    logic [LEN_W-1:0]  len_mask;
    logic [ADDR_W-1:0] addr_mask;

    always_comb begin
        w_d       = dec_width(width_code_i);
        b_d       = dec_burst(burst_code_i);
        pw_d      = dec_width(peer_width_code_i);
        pb_d      = dec_burst(peer_burst_code_i);
        own_sum   = {2'b00, w_d.lg} + {1'b0, b_d.lg};
        peer_sum  = {2'b00, pw_d.lg} + {1'b0, pb_d.lg};
        len_mask  = (LEN_W'(1) << w_d.lg) - LEN_W'(1);
        align_sh  = b_d.wrap ? own_sum : {2'b00, w_d.lg};
        addr_mask = (ADDR_W'(1) << align_sh) - ADDR_W'(1);

        cfg_bad_o  = !w_d.ok || !b_d.ok || !pw_d.ok || !pb_d.ok
                   || (len_i == '0) || ((len_i & len_mask) != '0)
                   || (own_sum != peer_sum);
        addr_bad_o = (addr_i & addr_mask) != '0;
        wlog_o     = w_d.lg;
        blog_o     = b_d.lg;
        wrap_o     = b_d.wrap;
    end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic [1:0]        wlog_i,
    input  logic [2:0]        blog_i,
    input  logic              wrap_i,
    input  logic              incr_i,
    output logic [ADDR_W-1:0] beat_next_o,
    output logic [ADDR_W-1:0] burst_next_o
);
    logic [ADDR_W-1:0] step, win, win_mask, stepped;
    logic [3:0]        win_lg;

    always_comb begin
        win_lg   = {2'b00, wlog_i} + {1'b0, blog_i};
        step     = ADDR_W'(1) << wlog_i;
        win      = ADDR_W'(1) << win_lg;
        win_mask = win - ADDR_W'(1);
        stepped  = cur_i + step;
        if (!incr_i) begin
            beat_next_o  = cur_i;
            burst_next_o = cur_i;
        end else if (wrap_i) begin
            beat_next_o  = (cur_i & ~win_mask) | (stepped & win_mask);
            burst_next_o = (cur_i & ~win_mask) + win;
        end else begin
            beat_next_o  = stepped;
            burst_next_o = stepped;
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [2:0]        width_code_i,
    input  logic [2:0]        burst_code_i,
    input  logic              incr_en_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [2:0]        peer_width_code_i,
    input  logic [2:0]        peer_burst_code_i,
    input  logic              addr_ready_i,
    output logic              addr_valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              block_done_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              addr_err_o,
    output logic              cfg_err_o
);
    localparam int MAX_BLOG = 4;
    localparam int CNT_W    = MAX_BLOG + 1;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        wlog;
        logic [2:0]        blog;
        logic              wrap;
        logic              incr;
        logic              aerr;
        logic              cerr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic              chk_cfg_bad, chk_addr_bad, chk_wrap;
    logic [1:0]        chk_wlog;
    logic [2:0]        chk_blog;
    logic [ADDR_W-1:0] nxt_beat, nxt_burst;
    logic [LEN_W-1:0]  step_len, rem_len;
    logic              fire, final_beat, burst_end;

    burst_cfg_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
        .width_code_i      (width_code_i),
        .burst_code_i      (burst_code_i),
        .peer_width_code_i (peer_width_code_i),
        .peer_burst_code_i (peer_burst_code_i),
        .addr_i            (start_addr_i),
        .len_i             (len_i),
        .cfg_bad_o         (chk_cfg_bad),
        .addr_bad_o        (chk_addr_bad),
        .wlog_o            (chk_wlog),
        .blog_o            (chk_blog),
        .wrap_o            (chk_wrap)
    );

    burst_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
        .cur_i        (st_q.addr),
        .wlog_i       (st_q.wlog),
        .blog_i       (st_q.blog),
        .wrap_i       (st_q.wrap),
        .incr_i       (st_q.incr),
        .beat_next_o  (nxt_beat),
        .burst_next_o (nxt_burst)
    );

    // Beats in the next burst: a full burst, or what is left if less.
    function automatic logic [CNT_W-1:0] clip_cnt(input logic [LEN_W-1:0] bytes,
                                                  input logic [1:0] wl,
                                                  input logic [2:0] bl);
        logic [LEN_W-1:0] beats, full;
        beats = bytes >> wl;
        full  = LEN_W'(1) << bl;
        return (beats < full) ? CNT_W'(beats) : CNT_W'(full);
    endfunction

    always_comb begin
        st_d       = st_q;
        step_len   = LEN_W'(1) << st_q.wlog;
        rem_len    = st_q.left - step_len;
        fire       = st_q.busy && addr_ready_i;
        final_beat = st_q.left == step_len;
        burst_end  = st_q.cnt == CNT_W'(1);

        if (!st_q.busy) begin
            if (start_i) begin
                st_d.cerr = chk_cfg_bad;
                st_d.aerr = !chk_cfg_bad && chk_addr_bad;
                if (!chk_cfg_bad && !chk_addr_bad) begin
                    st_d.busy = 1'b1;
                    st_d.addr = start_addr_i;
                    st_d.left = len_i;
                    st_d.wlog = chk_wlog;
                    st_d.blog = chk_blog;
                    st_d.wrap = chk_wrap;
                    st_d.incr = incr_en_i;
                    st_d.cnt  = clip_cnt(len_i, chk_wlog, chk_blog);
                end
            end
        end else if (fire) begin
            if (final_beat) begin
                st_d.busy = 1'b0;
                st_d.left = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.left = rem_len;
                if (burst_end) begin
                    st_d.addr = nxt_burst;
                    st_d.cnt  = clip_cnt(rem_len, st_q.wlog, st_q.blog);
                end else begin
                    st_d.addr = nxt_beat;
                    st_d.cnt  = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_valid_o = st_q.busy;
    assign addr_o       = st_q.addr;
    assign block_done_o = st_q.busy && burst_end;
    assign last_o       = st_q.busy && final_beat;
    assign busy_o       = st_q.busy;
    assign addr_err_o   = st_q.aerr;
    assign cfg_err_o    = st_q.cerr;

    // R7: a stalled beat keeps its address and strobes
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !addr_ready_i) |=>
            (addr_valid_o && $stable(addr_o) && $stable(block_done_o) && $stable(last_o)));

    // R6: the transfer-ending beat also ends its burst
    a_r6_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> block_done_o);

    // R6: accepting the final beat drops busy in the next cycle
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && last_o) |=> !busy_o);

    // R4: fixed-address mode never moves the address
    a_r4_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && !last_o && !st_q.incr) |=> $stable(addr_o));

    // R9: configuration error has priority over alignment error
    a_r9_single_error: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_err_o && cfg_err_o));

    // R8: every presented beat is aligned to the beat size
    a_r8_beat_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> ((addr_o & ((ADDR_W'(1) << st_q.wlog) - ADDR_W'(1))) == '0));

    // R8: a raised error flag never comes with a running transfer
    a_r8_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(addr_err_o) || $rose(cfg_err_o)) |-> !busy_o);
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] s_addr = '0;
    logic [2:0]  wc = 3'd1, bc = 3'd0, pwc = 3'd1, pbc = 3'd0;
    logic        incr = 1'b1;
    logic [12:0] len = 13'd1;
    logic        ready = 1'b1;
    logic        rnd_ready = 1'b0;
    logic        vld, blk, lst, bsy, aerr, cerr;
    logic [31:0] addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_on = 1'b0;
    string tag = "R1";

    int unsigned q_addr[$];
    bit          q_blk[$];
    bit          q_last[$];
    bit          m_busy = 0, m_aerr = 0, m_cerr = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(s_addr),
        .width_code_i(wc), .burst_code_i(bc), .incr_en_i(incr), .len_i(len),
        .peer_width_code_i(pwc), .peer_burst_code_i(pbc), .addr_ready_i(ready),
        .addr_valid_o(vld), .addr_o(addr), .block_done_o(blk), .last_o(lst),
        .busy_o(bsy), .addr_err_o(aerr), .cfg_err_o(cerr)
    );

    function automatic int wbytes(input logic [2:0] c);
        case (c) 3'd1: return 1; 3'd2: return 2; 3'd3: return 4; default: return 0; endcase
    endfunction
    function automatic int nbeats(input logic [2:0] c);
        case (c)
            3'd0: return 1; 3'd1, 3'd5: return 4; 3'd2, 3'd6: return 8;
            3'd3, 3'd7: return 16; default: return 0;
        endcase
    endfunction

    task automatic model_start();
        int w, b, l, win, left, n;
        int unsigned a, base;
        bit wrap, bad_c, bad_a;
        w = wbytes(wc); b = nbeats(bc); l = int'(len); wrap = bc >= 3'd5;
        bad_c = (w == 0) || (b == 0) || (wbytes(pwc) == 0) || (nbeats(pbc) == 0)
              || (l == 0) || (w != 0 && l % w != 0) || (w * b != wbytes(pwc) * nbeats(pbc));
        win = w * b;
        bad_a = !bad_c && ((wrap ? s_addr % win : s_addr % w) != 0);
        m_cerr = bad_c; m_aerr = bad_a;
        if (bad_c || bad_a) return;
        m_busy = 1; a = s_addr; left = l;
        while (left > 0) begin
            n = (left / w < b) ? left / w : b;
            base = a - (a % win);
            for (int k = 0; k < n; k++) begin
                if (!incr) q_addr.push_back(a);
                else if (wrap) q_addr.push_back(base + ((a + k * w) % win));
                else q_addr.push_back(a + k * w);
                q_blk.push_back(k == n - 1);
                q_last.push_back((k == n - 1) && (left == n * w));
            end
            left -= n * w;
            if (incr) a = wrap ? base + win : a + n * w;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_aerr = 0; m_cerr = 0;
            q_addr.delete(); q_blk.delete(); q_last.delete();
        end else if (m_busy) begin
            if (ready) begin
                void'(q_addr.pop_front()); void'(q_blk.pop_front()); void'(q_last.pop_front());
                if (q_addr.size() == 0) m_busy = 0;
            end
        end else if (start) begin
            model_start();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s/%s %s act=%0h exp=%0h t=%0t", tag, req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(vld == m_busy, "R2", "addr_valid", vld, m_busy);
            check(bsy == m_busy, "R6", "busy", bsy, m_busy);
            if (m_busy && vld) begin
                check(addr == q_addr[0], "R2", "addr", addr, q_addr[0]);
                check(blk == q_blk[0], "R5", "block_done", blk, q_blk[0]);
                check(lst == q_last[0], "R6", "last", lst, q_last[0]);
            end else begin
                check(!blk && !lst, "R6", "strobes idle", {blk, lst}, 0);
            end
            check(aerr == m_aerr, "R8", "addr_err", aerr, m_aerr);
            check(cerr == m_cerr, "R9", "cfg_err", cerr, m_cerr);
        end
        ready <= rnd_ready ? 1'($urandom % 2) : 1'b1;
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_sim();
        end
    end

    task automatic go(input string t, input int unsigned a, input logic [2:0] w,
                      input logic [2:0] b, input bit inc, input int l,
                      input logic [2:0] pw, input logic [2:0] pb);
        @(negedge clk);
        tag = t; s_addr = a; wc = w; bc = b; incr = inc; len = 13'(l);
        pwc = pw; pbc = pb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer(input string t, input int unsigned a, input logic [2:0] w,
                        input logic [2:0] b, input bit inc, input int l);
        go(t, a, w, b, inc, l, w, b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;
        tag = "R1";                                   // R1: reset state
        repeat (2) @(negedge clk);
        xfer("R2", 32'h100, 3'd3, 3'd1, 1'b1, 40);     // 4-byte beats, bursts 4,4,2
        xfer("R5", 32'h7,   3'd1, 3'd0, 1'b1, 5);      // single-beat bursts
        xfer("R5", 32'h20,  3'd2, 3'd2, 1'b1, 22);     // 8,3 beats
        xfer("R3", 32'h200, 3'd2, 3'd6, 1'b1, 40);     // wrap 8, window 16
        xfer("R3", 32'h40,  3'd1, 3'd5, 1'b1, 10);     // wrap 4, short tail
        xfer("R4", 32'h302, 3'd2, 3'd3, 1'b0, 36);     // fixed address
        rnd_ready = 1'b1;
        xfer("R7", 32'h1C0, 3'd3, 3'd7, 1'b1, 200);    // stalls, wrap 16
        xfer("R7", 32'h81,  3'd1, 3'd2, 1'b0, 30);
        rnd_ready = 1'b0;
        xfer("R8", 32'h102, 3'd3, 3'd1, 1'b1, 8);      // misaligned to width
        xfer("R8", 32'h108, 3'd3, 3'd5, 1'b1, 16);     // misaligned to window
        xfer("R8", 32'h108, 3'd3, 3'd1, 1'b1, 8);      // same address, non-wrap ok
        xfer("R9", 32'h0,   3'd0, 3'd1, 1'b1, 8);      // width code 0
        xfer("R9", 32'h0,   3'd4, 3'd1, 1'b1, 8);      // width code 4
        xfer("R9", 32'h0,   3'd1, 3'd4, 1'b1, 8);      // burst code 4
        xfer("R9", 32'h0,   3'd3, 3'd1, 1'b1, 6);      // length not a multiple
        xfer("R9", 32'h0,   3'd1, 3'd1, 1'b1, 0);      // zero length
        go("R9", 32'h0, 3'd2, 3'd1, 1'b1, 8, 3'd3, 3'd2);   // 8 vs 32 bytes per burst
        go("R9", 32'h5, 3'd1, 3'd3, 1'b1, 16, 3'd3, 3'd1);  // 16 vs 16, accepted
        xfer("R9", 32'h3,   3'd0, 3'd1, 1'b1, 8);      // both bad: cfg only
        xfer("R10", 32'h6,  3'd3, 3'd1, 1'b1, 8);      // addr_err set ...
        tag = "R10";
        repeat (5) @(negedge clk);                     // ... and held while idle
        @(negedge clk);
        s_addr = 32'h400; wc = 3'd1; bc = 3'd1; pwc = 3'd1; pbc = 3'd1;
        incr = 1'b1; len = 13'd64; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        s_addr = 32'h1; wc = 3'd3; start = 1'b1;       // ignored while busy
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk_on = 1'b0;
        finish_sim();
    end
endmodule